// File: doc/BRIEF.md
# Per-Block Write Protection Controller

This block keeps a protection level for every erase block of a flash array and decides, on request, whether a program or erase aimed at one block may go ahead. Firmware-facing command logic upstream issues lock, unlock, lock-down and protect-security commands, each with a block index. The array sequencer asks for a permit before it touches a block. A separate read port shows the current level of any block. The new state applies at once: a check in the same cycle as a command already sees that command's result.

A supply-lockout input denies every program and erase while it is high, whatever the block levels are. One block is the security block. A write-once bit protects it permanently. Only a power-on reset clears that bit. The ordinary reset puts every block back to locked and releases lock-down.

Commands arrive on a valid/ready channel. `cmd_ready` is low only while either reset is asserted, so commands are never stalled in normal operation. A command offered while `cmd_ready` is low is dropped. Checks take no back-pressure: each `chk_valid` cycle gives exactly one response cycle one clock later.

Top module: `wp_ctrl`

## Requirements
- R1: Command op encoding: 00 lock, 01 unlock, 10 lock-down, 11 protect-security. `cmd_ready` is high exactly when `rst_n` and `por_n` are both high. A command is accepted only when valid and ready are both high, and its effect is visible on `rd_state` after that clock edge.
- R2: A check answers on `rsp_valid`/`rsp_permit`/`rsp_err` in the cycle after `chk_valid`. The answer reflects any command accepted in the same cycle as the check.
- R3: After either reset, every block reads as locked. The state encoding is 00 unlocked, 01 locked, 11 locked-down.
- R4: A check is permitted only when the target block is unlocked. Locked and locked-down blocks are denied.
- R5: A locked-down block keeps state 11 through unlock and lock commands until the next reset.
- R6: While `vpp_low` is high during a check, the check is denied for every block.
- R7: A block index of NUM_BLOCKS or above has these effects:
  - On a lock, unlock or lock-down command, the command changes nothing and `cmd_err` pulses in the next cycle.
  - On a check, the check is denied and `rsp_err` is set.
  - On a read, `rd_state` returns 01.
- R8: Protect-security (op 11) sets `sec_perm`; its index is ignored. After that, checks on the security block (index 0) are denied whatever the block's level. `rst_n` leaves `sec_perm` set; only `por_n` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; relocks all blocks |
| por_n | input | 1 | Synchronous power-on reset, active low; also clears the permanent bit |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high together with valid |
| cmd_op | input | 2 | Command op code (R1) |
| cmd_idx | input | IDX_W | Target block of the command |
| cmd_err | output | 1 | Pulses after a command with an out-of-range index |
| vpp_low | input | 1 | Program supply below lockout threshold |
| chk_valid | input | 1 | Permit request |
| chk_idx | input | IDX_W | Block of the permit request |
| rsp_valid | output | 1 | Response available |
| rsp_permit | output | 1 | Program or erase may proceed |
| rsp_err | output | 1 | Request had an out-of-range index |
| rd_idx | input | IDX_W | Block to observe |
| rd_state | output | 2 | Protection level of `rd_idx` |
| sec_perm | output | 1 | Security block permanently protected |

## Verification
The bench targets these corner cases:

- **Command and check on the same block in one cycle.** A design that registers state before deciding would answer from the stale level.
- **Unlock and lock on a locked-down block.** A design that lets either command through would reopen or downgrade a block that should stay fixed.
- **Ordinary reset after permanent protection.** A design that clears the bit on `rst_n` would hand the security block back.
- **Indices 71 and 127.** A design without the range guard would alias them onto real blocks.
- **`vpp_low` high while the target block is unlocked.** A design that ignores the supply override would permit the operation.

A long random walk, compared against the behavioural model on every clock, covers the mixed orderings.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    OP_LOCK   = 2'b00,
    OP_UNLOCK = 2'b01,
    OP_LDOWN  = 2'b10,
    OP_SECURE = 2'b11
  } wp_op_e;

  typedef enum logic [1:0] {
    ST_OPEN   = 2'b00,
    ST_LOCKED = 2'b01,
    ST_LDOWN  = 2'b11
  } wp_st_e;
endpackage

// File: rtl/wp_cell.sv
module wp_cell
  import wp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sel,
  input  wp_op_e op,
  output wp_st_e cur,
  output wp_st_e nxt
);
  // One block's level; lock-down is only left through reset.
  always_comb begin
    nxt = cur;
    if (sel) begin
      case (op)
        OP_LOCK:   if (cur != ST_LDOWN) nxt = ST_LOCKED;
        OP_UNLOCK: if (cur != ST_LDOWN) nxt = ST_OPEN;
        OP_LDOWN:  nxt = ST_LDOWN;
        default:   nxt = cur;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur <= ST_LOCKED;
    else        cur <= nxt;
  end
endmodule

// File: rtl/wp_decide.sv
module wp_decide
  import wp_pkg::*;
(
  input  wp_st_e st,
  input  logic   idx_ok,
  input  logic   vpp_low,
  input  logic   is_sec,
  input  logic   perm,
  output logic   permit
);
  always_comb begin
    permit = idx_ok && !vpp_low && (st == ST_OPEN) && !(is_sec && perm);
  end
endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
  import wp_pkg::*;
#(
  parameter int NUM_BLOCKS = 71,
  parameter int SEC_BLOCK  = 0,
  parameter int IDX_W      = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_idx,
  output logic             cmd_err,
  input  logic             vpp_low,
  input  logic             chk_valid,
  input  logic [IDX_W-1:0] chk_idx,
  output logic             rsp_valid,
  output logic             rsp_permit,
  output logic             rsp_err,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_state,
  output logic             sec_perm
);
  localparam logic [IDX_W-1:0] SEC_IDX = IDX_W'(SEC_BLOCK);

  logic   run_n;
  logic   cmd_fire;
  logic   cmd_ok, chk_ok, rd_ok;
  wp_op_e op;
  logic   perm_q, perm_nxt;
  wp_st_e cur_st [NUM_BLOCKS];
  wp_st_e nxt_st [NUM_BLOCKS];
  wp_st_e chk_st;
  logic   permit_c;

  assign run_n     = rst_n & por_n;
  assign cmd_ready = run_n;
  assign cmd_fire  = cmd_valid & cmd_ready;
  assign op        = wp_op_e'(cmd_op);
  assign cmd_ok    = int'(cmd_idx) < NUM_BLOCKS;
  assign chk_ok    = int'(chk_idx) < NUM_BLOCKS;
  assign rd_ok     = int'(rd_idx)  < NUM_BLOCKS;

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
    logic sel;
    assign sel = cmd_fire && cmd_ok && (op != OP_SECURE) && (cmd_idx == IDX_W'(g));
    wp_cell u_cell (
      .clk  (clk),
      .rst_n(run_n),
      .sel  (sel),
      .op   (op),
      .cur  (cur_st[g]),
      .nxt  (nxt_st[g])
    );
  end

  // Permanent bit: write-once, only the power-on reset clears it.
  assign perm_nxt = perm_q | (cmd_fire && op == OP_SECURE);
  always_ff @(posedge clk) begin
    if (!por_n) perm_q <= 1'b0;
    else        perm_q <= perm_nxt;
  end
  assign sec_perm = perm_q;

  // Checks look at the post-command state so a change applies immediately.
  assign chk_st = chk_ok ? nxt_st[chk_idx] : ST_LOCKED;

  wp_decide u_decide (
    .st     (chk_st),
    .idx_ok (chk_ok),
    .vpp_low(vpp_low),
    .is_sec (chk_idx == SEC_IDX),
    .perm   (perm_nxt),
    .permit (permit_c)
  );

  always_ff @(posedge clk) begin
    if (!run_n) begin
      rsp_valid  <= 1'b0;
      rsp_permit <= 1'b0;
      rsp_err    <= 1'b0;
      cmd_err    <= 1'b0;
    end else begin
      rsp_valid  <= chk_valid;
      rsp_permit <= chk_valid && permit_c;
      rsp_err    <= chk_valid && !chk_ok;
      cmd_err    <= cmd_fire && (op != OP_SECURE) && !cmd_ok;
    end
  end

  assign rd_state = rd_ok ? cur_st[rd_idx] : ST_LOCKED;
endmodule

// File: rtl/wp_ctrl_chk.sv
module wp_ctrl_chk #(
  parameter int NUM_BLOCKS = 71,
  parameter int SEC_BLOCK  = 0,
  parameter int IDX_W      = $clog2(NUM_BLOCKS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             por_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_op,
  input logic [IDX_W-1:0] cmd_idx,
  input logic             cmd_err,
  input logic             vpp_low,
  input logic             chk_valid,
  input logic [IDX_W-1:0] chk_idx,
  input logic             rsp_valid,
  input logic             rsp_permit,
  input logic             rsp_err,
  input logic [IDX_W-1:0] rd_idx,
  input logic [1:0]       rd_state,
  input logic             sec_perm
);
  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    chk_valid |=> rsp_valid);

  p_ldown_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (rd_state == 2'b11) |=> (rd_idx != $past(rd_idx)) || (rd_state == 2'b11));

  p_vpp_deny_r6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (chk_valid && vpp_low) |=> !rsp_permit);

  p_range_deny_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (chk_valid && int'(chk_idx) >= NUM_BLOCKS) |=> (rsp_err && !rsp_permit));

  p_perm_sticky_r8: assert property (@(posedge clk) disable iff (!por_n)
    sec_perm |=> sec_perm);

  p_sec_deny_r8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (chk_valid && sec_perm && chk_idx == IDX_W'(SEC_BLOCK)) |=> !rsp_permit);

  p_permit_has_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    rsp_permit |-> rsp_valid && !rsp_err);
endmodule

bind wp_ctrl wp_ctrl_chk #(.NUM_BLOCKS(NUM_BLOCKS), .SEC_BLOCK(SEC_BLOCK), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_wp_ctrl.sv
module tb_wp_ctrl;
  localparam int N  = 71;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0, por_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = 2'b00;
  logic [IW-1:0] cmd_idx = '0, chk_idx = '0, rd_idx = '0;
  logic cmd_err, vpp_low = 1'b0, chk_valid = 1'b0;
  logic rsp_valid, rsp_permit, rsp_err, sec_perm;
  logic [1:0] rd_state;

  int n_chk = 0, n_fail = 0;
  int m [N];
  bit m_perm = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wp_ctrl dut (.*);

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One clock: drive, update the model at the edge, compare just after it.
  task automatic step(input bit cv, input int op, input int ci,
                      input bit kv, input int ki, input bit vl,
                      input int ri, input string tag);
    int e_rv, e_rp, e_re, e_ce, e_rd, e_rdy;
    @(negedge clk);
    cmd_valid = cv; cmd_op = op[1:0]; cmd_idx = ci[IW-1:0];
    chk_valid = kv; chk_idx = ki[IW-1:0]; vpp_low = vl; rd_idx = ri[IW-1:0];
    e_rdy = (rst_n && por_n) ? 1 : 0;
    cmp(tag, "R1 cmd_ready", int'(cmd_ready), e_rdy);
    @(posedge clk);
    if (!por_n) m_perm = 1'b0;
    if (!(rst_n && por_n)) begin
      for (int i = 0; i < N; i++) m[i] = 1;
      e_rv = 0; e_rp = 0; e_re = 0; e_ce = 0;
    end else begin
      e_ce = 0;
      if (cv) begin
        if (op == 3) m_perm = 1'b1;
        else if (ci >= N) e_ce = 1;
        else if (m[ci] != 3) m[ci] = (op == 0) ? 1 : (op == 1) ? 0 : 3;
        else m[ci] = 3;
      end
      e_rv = kv;
      e_re = (kv && ki >= N) ? 1 : 0;
      e_rp = (kv && ki < N && !vl && !(ki == 0 && m_perm)) ? ((m[ki] == 0) ? 1 : 0) : 0;
    end
    e_rd = (ri < N) ? m[ri] : 1;
    #2;
    cmp(tag, "R2 rsp_valid",  int'(rsp_valid),  e_rv);
    cmp(tag, "R4 rsp_permit", int'(rsp_permit), e_rp);
    cmp(tag, "R7 rsp_err",    int'(rsp_err),    e_re);
    cmp(tag, "R7 cmd_err",    int'(cmd_err),    e_ce);
    cmp(tag, "R3 rd_state",   int'(rd_state),   e_rd);
    cmp(tag, "R8 sec_perm",   int'(sec_perm),   int'(m_perm));
  endtask

  task automatic idle(input int ri, input string tag);
    step(0, 0, 0, 0, 0, 0, ri, tag);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m[i] = 1;
    rst_n = 1'b0; por_n = 1'b0;
    step(1, 1, 3, 1, 3, 0, 3, "R1 cmd during reset");
    idle(0, "R3 reset");
    rst_n = 1'b1; por_n = 1'b1;
    for (int i = 0; i < N; i++) idle(i, "R3 all locked");
    step(0, 0, 0, 1, 5, 0, 5, "R4 locked denies");
    step(1, 1, 5, 1, 5, 0, 5, "R2 unlock same-cycle permit");
    step(1, 0, 5, 1, 5, 0, 5, "R4 relock denies");
    step(1, 1, 10, 0, 0, 0, 10, "R1 unlock 10");
    step(1, 2, 10, 1, 10, 0, 10, "R5 lockdown denies");
    step(1, 1, 10, 1, 10, 0, 10, "R5 unlock ignored");
    step(1, 0, 10, 1, 10, 0, 10, "R5 lock no downgrade");
    step(1, 1, 20, 1, 20, 1, 20, "R6 vpp low denies");
    step(0, 0, 0, 1, 20, 0, 20, "R6 vpp ok permits");
    step(1, 2, 71, 1, 71, 0, 71, "R7 index 71");
    step(1, 1, 127, 1, 127, 0, 100, "R7 index 127");
    step(1, 1, 0, 1, 0, 0, 0, "R8 sec unlocked permits");
    step(1, 3, 99, 1, 0, 0, 0, "R8 protect same cycle");
    step(1, 1, 0, 1, 0, 0, 0, "R8 sec stays denied");
    rst_n = 1'b0;
    idle(10, "R8 rst keeps perm");
    rst_n = 1'b1;
    idle(10, "R3 lockdown released");
    step(1, 1, 10, 1, 10, 0, 10, "R5 unlock after reset");
    step(1, 1, 0, 1, 0, 0, 0, "R8 sec denied after rst");
    por_n = 1'b0;
    idle(0, "R8 por clears perm");
    por_n = 1'b1;
    step(1, 1, 0, 1, 0, 0, 0, "R8 sec usable after por");
    for (int k = 0; k < 3000; k++) begin
      int op, ci, ki;
      op = ($urandom % 16 == 0) ? 3 : int'($urandom % 3);
      ci = int'($urandom % 80);
      ki = int'($urandom % 80);
      if (k % 700 == 699) rst_n = 1'b0;
      else rst_n = 1'b1;
      step($urandom % 2 == 1, op, ci, $urandom % 2 == 1, ki,
           $urandom % 8 == 0, int'($urandom % 80), "R4 random walk");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule